// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Timebase

This block is the triangle-wave counter behind one PWM channel. While running it climbs from zero to a programmable period and falls back to zero, repeating with a cycle of twice the period in clocks. Compare logic downstream uses the counter value, the present count direction and two single-cycle strobes: one when the counter reaches zero and one when it reaches the period.

Several instances can be strung into a chain. Each link either emits its own pulse at zero, as the master does, or forwards the pulse it receives to the next link. A link with phase loading enabled jumps to its phase value on an incoming pulse and leaves in a chosen direction. Followers set to half the period and to the full period then trail the master by fixed fractions of a cycle. One shared run gate freezes every counter while software sets them up and releases them together. While the gate is closed the counter can also be written directly. It keeps its value otherwise, including across changes of period and phase.

Top module: `pwm_updown_timebase`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the counter reads 0, the direction output reads 1 (up), both event strobes are low and the sync output is low when the sync select is 0.
- R2: With the gate open and no phase load, the counter steps by exactly one per clock, going 0,1,…,P,P-1,…,1,0 for a period input P (P = 2000 in the long run), so it repeats every 2P clocks.
- R3: The direction output is 1 whenever the counter is 0 and 0 whenever the counter is nonzero and at or above the period; otherwise it gives the direction of the last step. The counter leaves 0 upward and leaves the period (or any higher value) downward, whatever direction a phase load set.
- R4: The zero strobe is high for exactly one cycle when the counter arrives at 0 by counting, and the period strobe likewise when it arrives at the period by counting. Values placed by reset, by a phase load or by a direct write raise no strobe.
- R5: With sync select 0 (emit on zero), the sync output equals the zero strobe.
- R6: With sync select 1 (pass-through), the sync output follows the sync input in the same cycle, and the zero strobe does not reach it.
- R7: With the gate open, phase loading enabled and the sync input high, the counter takes the phase value on the next clock and its direction register takes the phase-direction bit (1 = up). With phase loading disabled the sync input does not disturb counting.
- R8: A phase load that leaves the counter at or above the period with direction up makes the next step a decrement.
- R9: With the gate closed the counter holds its value and ignores the sync input. Opening the gate starts every chained instance on the same clock.
- R10: With the gate closed, a write strobe loads the written value on the next clock, keeping the direction register. With the gate open the write strobe is ignored. Period and phase changes never alter the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Shared timebase gate; 1 lets the counter step |
| period | input | CNT_W | Turn-around value of the triangle |
| phase | input | CNT_W | Value taken on a phase load |
| phase_en | input | 1 | 1 lets the sync input load the phase |
| phase_up | input | 1 | Direction after a phase load, 1 = up |
| sync_sel | input | 1 | 0 = pulse on zero, 1 = forward sync input |
| sync_in | input | 1 | Sync pulse from the previous link |
| cnt_wr | input | 1 | Direct counter write, honoured only with the gate closed |
| cnt_wdata | input | CNT_W | Value for the direct write |
| count | output | CNT_W | Counter value |
| dir_up | output | 1 | Present count direction, 1 = up |
| zero_evt | output | 1 | One-cycle strobe on arrival at zero |
| prd_evt | output | 1 | One-cycle strobe on arrival at the period |
| sync_out | output | 1 | Sync pulse to the next link |

## Verification
The bench targets the turn-around points. A design that flips direction one cycle late would overshoot the period or wrap below zero. Phase loads at and above the period are driven with direction up. A counter that trusted the loaded direction would climb away from the period and never return. The bench also checks that loads and writes raise no strobes and that a write is ignored while running: a design that got this wrong would emit spurious sync pulses or disturb a running follower. A four-link chain released from a closed gate checks that the followers take their phases on the master's first zero. A counter that drifts from the loaded direction or skips a cycle there shows up as the wrong follower values at a fixed offset after that pulse.

// File: rtl/pwm_updown_timebase.sv
module pwm_updown_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  input  logic             phase_en,
  input  logic             phase_up,
  input  logic             sync_sel,
  input  logic             sync_in,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             zero_evt,
  output logic             prd_evt,
  output logic             sync_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_step;
  logic             dir_q, moved_q;

  wire at_zero  = (cnt_q == '0);
  wire at_top   = !at_zero && (cnt_q >= period);
  wire eff_up   = at_zero | (!at_top & dir_q);
  wire load_now = run & phase_en & sync_in;

  always_comb begin
    if (at_zero)
      cnt_step = (period == '0) ? cnt_q : cnt_q + ONE;
    else if (eff_up)
      cnt_step = cnt_q + ONE;
    else
      cnt_step = cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dir_q   <= 1'b1;
      moved_q <= 1'b0;
    end else if (run) begin
      if (load_now) begin
        cnt_q   <= phase;
        dir_q   <= phase_up;
        moved_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_step;
        dir_q   <= eff_up;
        moved_q <= (cnt_step != cnt_q);
      end
    end else begin
      moved_q <= 1'b0;
      if (cnt_wr)
        cnt_q <= cnt_wdata;
    end
  end

  assign count    = cnt_q;
  assign dir_up   = eff_up;
  assign zero_evt = moved_q & at_zero;
  assign prd_evt  = moved_q & !at_zero & (cnt_q == period);
  assign sync_out = sync_sel ? sync_in : zero_evt;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load_now && count != '0 && count < period
    |=> (count == $past(count) + ONE) || (count == $past(count) - ONE));

  p_leave_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load_now && count == '0 && period != '0 |=> count == ONE);

  p_leave_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load_now && count != '0 && count >= period
    |=> count == $past(count) - ONE);

  p_zero_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !zero_evt);

  p_sync_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_sel && sync_out |-> count == '0 && $past(run));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> count == $past(phase) && !zero_evt && !prd_evt);

  p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(count));

  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run && cnt_wr |=> count == $past(cnt_wdata));

endmodule

// File: tb/pwm_updown_timebase_tb.sv
module pwm_updown_timebase_tb;
  localparam int CLK_P = 10;
  localparam int W = 16;
  localparam int BIG = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [W-1:0] m_period = 16'd5, m_phase = '0, m_wdata = '0;
  logic m_phase_en = 1'b0, m_phase_up = 1'b0, m_sel = 1'b0, m_sync = 1'b0, m_wr = 1'b0;
  logic [W-1:0] m_cnt;
  logic m_dir, m_zero, m_prd, m_sout;

  logic f2_wr = 1'b0, f3_wr = 1'b0, f4_wr = 1'b0;
  logic [W-1:0] f2_cnt, f3_cnt, f4_cnt;
  logic f2_dir, f3_dir, f4_dir, f2_z, f3_z, f4_z, f2_p, f3_p, f4_p;
  logic f2_so, f3_so, f4_so;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_updown_timebase #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .period(m_period), .phase(m_phase),
    .phase_en(m_phase_en), .phase_up(m_phase_up), .sync_sel(m_sel), .sync_in(m_sync),
    .cnt_wr(m_wr), .cnt_wdata(m_wdata), .count(m_cnt), .dir_up(m_dir),
    .zero_evt(m_zero), .prd_evt(m_prd), .sync_out(m_sout));

  pwm_updown_timebase #(.CNT_W(W)) u_f2 (
    .clk(clk), .rst_n(rst_n), .run(run), .period(W'(BIG)), .phase(W'(BIG/2)),
    .phase_en(1'b1), .phase_up(1'b0), .sync_sel(1'b1), .sync_in(m_sout),
    .cnt_wr(f2_wr), .cnt_wdata(W'(BIG/2)), .count(f2_cnt), .dir_up(f2_dir),
    .zero_evt(f2_z), .prd_evt(f2_p), .sync_out(f2_so));

  pwm_updown_timebase #(.CNT_W(W)) u_f3 (
    .clk(clk), .rst_n(rst_n), .run(run), .period(W'(BIG)), .phase(W'(BIG)),
    .phase_en(1'b1), .phase_up(1'b0), .sync_sel(1'b1), .sync_in(f2_so),
    .cnt_wr(f3_wr), .cnt_wdata(W'(BIG)), .count(f3_cnt), .dir_up(f3_dir),
    .zero_evt(f3_z), .prd_evt(f3_p), .sync_out(f3_so));

  pwm_updown_timebase #(.CNT_W(W)) u_f4 (
    .clk(clk), .rst_n(rst_n), .run(run), .period(W'(BIG)), .phase(W'(BIG/2)),
    .phase_en(1'b1), .phase_up(1'b1), .sync_sel(1'b1), .sync_in(f3_so),
    .cnt_wr(f4_wr), .cnt_wdata(W'(BIG/2)), .count(f4_cnt), .dir_up(f4_dir),
    .zero_evt(f4_z), .prd_evt(f4_p), .sync_out(f4_so));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    chk("R1", "count in reset", int'(m_cnt), 0);
    tick();
    chk("R1", "count after reset", int'(m_cnt), 0);
    chk("R1", "dir after reset", int'(m_dir), 1);
    chk("R1", "zero strobe", int'(m_zero), 0);
    chk("R1", "period strobe", int'(m_prd), 0);
    chk("R1", "sync out", int'(m_sout), 0);
  endtask

  task automatic t_triangle();
    m_period = 16'd5; m_sel = 1'b0; m_phase_en = 1'b0; m_sync = 1'b0;
    run = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      int ph, c, d;
      tick();
      ph = k % 10;
      c  = (ph <= 5) ? ph : 10 - ph;
      d  = (c == 0) ? 1 : (c >= 5) ? 0 : (ph < 5 ? 1 : 0);
      chk("R2", "triangle count", int'(m_cnt), c);
      chk("R3", "direction", int'(m_dir), d);
      chk("R4", "zero strobe", int'(m_zero), (c == 0) ? 1 : 0);
      chk("R4", "period strobe", int'(m_prd), (c == 5) ? 1 : 0);
      chk("R5", "sync on zero", int'(m_sout), (c == 0) ? 1 : 0);
    end
  endtask

  task automatic t_phase_load();
    m_period = 16'd10; m_phase = 16'd7; m_phase_up = 1'b0; m_phase_en = 1'b1; m_sync = 1'b1;
    tick(); m_sync = 1'b0;
    chk("R7", "loaded phase", int'(m_cnt), 7);
    chk("R7", "loaded dir down", int'(m_dir), 0);
    chk("R4", "no strobe on load", int'(m_zero | m_prd), 0);
    tick();
    chk("R7", "step after down load", int'(m_cnt), 6);
    m_phase = 16'd3; m_phase_up = 1'b1; m_sync = 1'b1;
    tick(); m_sync = 1'b0;
    chk("R7", "loaded phase up", int'(m_cnt), 3);
    chk("R7", "loaded dir up", int'(m_dir), 1);
    tick();
    chk("R7", "step after up load", int'(m_cnt), 4);
    m_phase_en = 1'b0; m_phase = 16'd7; m_sync = 1'b1;
    tick(); m_sync = 1'b0;
    chk("R7", "sync ignored when disabled", int'(m_cnt), 5);
  endtask

  task automatic t_load_above();
    m_phase_en = 1'b1; m_phase = 16'd12; m_phase_up = 1'b1; m_sync = 1'b1;
    tick(); m_sync = 1'b0;
    chk("R8", "load above period", int'(m_cnt), 12);
    chk("R3", "dir forced down", int'(m_dir), 0);
    tick();
    chk("R8", "decrement from above", int'(m_cnt), 11);
    tick();
    chk("R8", "reach period", int'(m_cnt), 10);
    chk("R4", "period strobe by counting", int'(m_prd), 1);
    tick();
    chk("R8", "below period", int'(m_cnt), 9);
    m_phase = 16'd10; m_sync = 1'b1;
    tick(); m_sync = 1'b0;
    chk("R8", "load at period", int'(m_cnt), 10);
    chk("R4", "no period strobe on load", int'(m_prd), 0);
    tick();
    chk("R8", "turn down after load at period", int'(m_cnt), 9);
  endtask

  task automatic t_gate();
    run = 1'b0; m_phase = 16'd2;
    for (int i = 0; i < 5; i++) begin
      m_sync = (i == 2);
      tick();
      chk("R9", "held while gated", int'(m_cnt), 9);
    end
    m_sync = 1'b0;
    run = 1'b1;
    tick();
    chk("R9", "resume after gate", int'(m_cnt), 8);
  endtask

  task automatic t_write();
    run = 1'b0; m_wr = 1'b1; m_wdata = 16'd4;
    tick(); m_wr = 1'b0;
    chk("R10", "direct write", int'(m_cnt), 4);
    chk("R4", "no strobe on write", int'(m_zero | m_prd), 0);
    m_period = 16'd6; m_phase = 16'd2;
    tick();
    chk("R10", "kept across period change", int'(m_cnt), 4);
    tick();
    chk("R10", "still kept", int'(m_cnt), 4);
    run = 1'b1; m_wr = 1'b1; m_wdata = 16'd9;
    tick(); m_wr = 1'b0;
    chk("R10", "write ignored while running", int'(m_cnt), 3);
  endtask

  task automatic t_passthru();
    int guard;
    m_phase_en = 1'b0; m_sel = 1'b1; m_sync = 1'b1;
    #1;
    chk("R6", "forward high", int'(m_sout), 1);
    m_sync = 1'b0;
    #1;
    chk("R6", "forward low", int'(m_sout), 0);
    guard = 0;
    while (!m_zero && guard < 30) begin
      tick(); guard++;
    end
    chk("R4", "zero reached", int'(m_zero), 1);
    chk("R6", "zero strobe blocked", int'(m_sout), 0);
    m_sel = 1'b0;
  endtask

  task automatic t_chain();
    int nz, np;
    t_reset();
    m_period = W'(BIG); m_phase_en = 1'b0; m_sel = 1'b0; m_sync = 1'b0;
    m_wr = 1'b1; m_wdata = '0; f2_wr = 1'b1; f3_wr = 1'b1; f4_wr = 1'b1;
    tick();
    m_wr = 1'b0; f2_wr = 1'b0; f3_wr = 1'b0; f4_wr = 1'b0;
    chk("R10", "follower write", int'(f3_cnt), BIG);
    run = 1'b1;
    nz = 0; np = 0;
    for (int k = 1; k <= 2*BIG + 1 + BIG/4; k++) begin
      tick();
      nz += int'(m_zero);
      np += int'(m_prd);
      if (k == 1) begin
        chk("R9", "master starts", int'(m_cnt), 1);
        chk("R9", "f2 starts", int'(f2_cnt), BIG/2 + 1);
        chk("R9", "f3 starts", int'(f3_cnt), BIG - 1);
        chk("R9", "f4 starts", int'(f4_cnt), BIG/2 + 1);
      end
      if (k == BIG) chk("R2", "master top", int'(m_cnt), BIG);
      if (k == 2*BIG) begin
        chk("R2", "master back at zero", int'(m_cnt), 0);
        chk("R5", "master sync", int'(m_sout), 1);
        chk("R6", "chain forwards", int'(f3_so), 1);
      end
      if (k == 2*BIG + 1) begin
        chk("R7", "f2 phase", int'(f2_cnt), BIG/2);
        chk("R7", "f3 phase", int'(f3_cnt), BIG);
        chk("R7", "f4 phase", int'(f4_cnt), BIG/2);
        chk("R7", "f2 dir", int'(f2_dir), 0);
        chk("R7", "f4 dir", int'(f4_dir), 1);
      end
    end
    chk("R2", "master after lag", int'(m_cnt), BIG/4 + 1);
    chk("R7", "f2 after lag", int'(f2_cnt), BIG/2 - BIG/4);
    chk("R7", "f3 after lag", int'(f3_cnt), BIG - BIG/4);
    chk("R7", "f4 after lag", int'(f4_cnt), BIG/2 + BIG/4);
    chk("R4", "zero strobes in window", nz, 1);
    chk("R4", "period strobes in window", np, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_triangle();
    t_phase_load();
    t_load_above();
    t_gate();
    t_write();
    t_passthru();
    t_chain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule